// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block keeps eight 80-bit extended-precision registers that a floating-point datapath uses as a circular stack. A 3-bit top pointer names the current top. Every stack-relative slot ST(i) maps to physical register (top + i) mod 8. Each physical register has a 2-bit tag. The tag is recomputed in hardware from the stored value whenever the register is written, and it is forced to Empty when the register is popped or freed. The eight tags together make up a 16-bit tag word, which can be read out and reloaded as one unit to save and restore a context.

A push writes below the current top. A pop retires the top. Random access reads and writes use an offset from the top, and a free marks one slot as empty. Stack misuse is found from the tags rather than from a depth counter. Pushing onto an occupied slot raises an overflow pulse. Popping or reading an empty slot raises an underflow pulse.

Top module: `fp_regstack`

## Requirements
- R1: Synchronous active-low reset sets the top pointer to 0, sets every tag to Empty (tag word 16'hFFFF) and clears both flags.
- R2: An accepted push first moves the top pointer down by one (mod 8) and then stores the value at the new top, so that ST(0) reads it back.
- R3: A push whose target register is not Empty is refused. The next cycle shows the overflow flag high, and the top pointer, the data and the tags are left unchanged.
- R4: A pop of a non-empty top sets that register's tag to Empty (11) and moves the top pointer up by one (mod 8).
- R5: A pop whose top register is Empty, or a read request (read enable) of an Empty ST(i), raises the underflow flag on the next cycle. A refused pop leaves the top pointer unchanged.
- R6: The tag of a written value uses bit 79 as sign, bits 78:64 as exponent, bit 63 as integer bit and bits 62:0 as fraction. The tag is Zero (01) when the exponent and bits 63:0 are all zero. It is Special (10) when the exponent is zero with a nonzero significand, when the exponent is all ones, or when the integer bit is clear under any other exponent. Otherwise it is Valid (00).
- R7: The read port returns physical register (top + i) mod 8 combinationally. A write to ST(i) stores into the same register and retags it per R6 without moving the top pointer.
- R8: A free of ST(i) sets that register's tag to Empty and leaves the top pointer and the data unchanged.
- R9: Tag n occupies tag-word bits [2n+1:2n]. A tag-word load replaces all eight tags in one cycle, and the loaded word is visible on the next cycle.
- R10: Only one change is applied per cycle, chosen by priority: tag load, then push, then pop, then write, then free. A lower request in the same cycle has no effect and raises no flag.
- R11: Each flag is a one-cycle pulse in the cycle after the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push request |
| push_data | input | 80 | Value to push |
| pop_valid | input | 1 | Pop request |
| rd_en | input | 1 | Read request, checked for underflow |
| rd_idx | input | 3 | Stack offset for the read port |
| rd_data | output | 80 | Contents of ST(rd_idx) |
| wr_en | input | 1 | Write request to ST(wr_idx) |
| wr_idx | input | 3 | Stack offset for the write |
| wr_data | input | 80 | Value to write |
| free_en | input | 1 | Free request for ST(free_idx) |
| free_idx | input | 3 | Stack offset to free |
| tagw_load | input | 1 | Load the whole tag word |
| tagw_in | input | 16 | Tag word to load |
| tagw_out | output | 16 | Current tag word |
| top_ptr | output | 3 | Current top-of-stack pointer |
| ovf_flag | output | 1 | Overflow pulse |
| unf_flag | output | 1 | Underflow pulse |

## Verification
A wrong top pointer appears on the very next cycle. The top pointer is shown on its own port, and ST(0) on the read port then returns a different register's data. A wrong tag appears one cycle after the write, pop, free or load that produced it, because the tag word is visible directly. It also shows up indirectly when a later push or pop raises an overflow or underflow that it should not, or fails to raise one that it should. Corrupted data stays hidden until its slot is read through the read port, so the stimulus reads back every slot it has written.

// File: rtl/fpstk_pkg.sv
// Shared types for the tagged register stack.
// Assumes the 80-bit layout: sign, 15-bit exponent, integer bit, 63-bit fraction.
package fpstk_pkg;
    localparam int EXP_W  = 15;
    localparam int FRAC_W = 63;
    localparam int REG_W  = 1 + EXP_W + 1 + FRAC_W;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;
endpackage

// File: rtl/fpstk_classify.sv
// Combinational classifier: maps an extended-precision value to its tag.
// Assumes the layout {sign, exponent, integer bit, fraction}; never yields Empty.
module fpstk_classify
    import fpstk_pkg::*;
#(
    parameter int EW = 15,
    parameter int FW = 63,
    localparam int W = 1 + EW + 1 + FW
) (
    input  logic [W-1:0] value,
    output tag_e         tag
);
    logic [EW-1:0] expo;
    logic          ibit;
    logic [FW-1:0] frac;

    assign expo = value[W-2 -: EW];
    assign ibit = value[FW];
    assign frac = value[FW-1:0];

    // Pick the tag from exponent, integer bit and fraction.
    always_comb begin
        if (expo == '0) begin
            tag = (!ibit && frac == '0) ? TAG_ZERO : TAG_SPECIAL;
        end else if (expo == '1) begin
            tag = TAG_SPECIAL;
        end else if (!ibit) begin
            tag = TAG_SPECIAL;
        end else begin
            tag = TAG_VALID;
        end
    end
endmodule

// File: rtl/fpstk_datafile.sv
// Register array with one write port and one combinational read port.
// Assumes at most one write per cycle; contents clear to zero on reset.
module fpstk_datafile #(
    parameter int DEPTH = 8,
    parameter int W     = 80,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        // Hold one register; load it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && waddr == AW'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fpstk_tagfile.sv
// Tag storage: one 2-bit tag per physical register, exposed as a packed word.
// Assumes whole-word load and single-entry update are never asked for together.
module fpstk_tagfile
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = 2 * DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [TW-1:0] load_word,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  tag_e          set_tag,
    output logic [TW-1:0] tag_word
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        // Track one tag: reset to Empty, bulk load, or single update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_word[2*g +: 2] <= TAG_EMPTY;
            end else if (load_en) begin
                tag_word[2*g +: 2] <= load_word[2*g +: 2];
            end else if (set_en && set_idx == AW'(g)) begin
                tag_word[2*g +: 2] <= set_tag;
            end
        end
    end
endmodule

// File: rtl/fp_regstack.sv
// Tagged circular register stack: push, pop, relative read/write, free,
// and tag-word save/restore. One state change per cycle, by fixed priority.
// Assumes the caller respects the flags; refused requests change nothing.
module fp_regstack
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG),
    localparam int TW  = 2 * NREG,
    localparam int W   = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    input  logic          pop_valid,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          free_en,
    input  logic [AW-1:0] free_idx,
    input  logic          tagw_load,
    input  logic [TW-1:0] tagw_in,
    output logic [TW-1:0] tagw_out,
    output logic [AW-1:0] top_ptr,
    output logic          ovf_flag,
    output logic          unf_flag
);
    logic [AW-1:0] top_q;
    logic [AW-1:0] push_phys, rd_phys, wr_phys, free_phys;
    logic          sel_push, sel_pop, sel_wr, sel_free;
    logic          push_ok, pop_ok;
    tag_e          tag_push, tag_top, tag_rd, cls_tag;
    logic [W-1:0]  cls_in;
    logic          d_we, t_set;
    logic [AW-1:0] d_addr, t_idx;
    tag_e          t_val;

    // Map stack offsets to physical registers.
    always_comb begin
        push_phys = top_q - AW'(1);
        rd_phys   = top_q + rd_idx;
        wr_phys   = top_q + wr_idx;
        free_phys = top_q + free_idx;
    end

    // Look up tags of the registers each request touches.
    always_comb begin
        tag_push = tag_e'(tagw_out[2*push_phys +: 2]);
        tag_top  = tag_e'(tagw_out[2*top_q +: 2]);
        tag_rd   = tag_e'(tagw_out[2*rd_phys +: 2]);
    end

    // Arbitrate: load > push > pop > write > free.
    always_comb begin
        sel_push = push_valid && !tagw_load;
        sel_pop  = pop_valid && !tagw_load && !push_valid;
        sel_wr   = wr_en && !tagw_load && !push_valid && !pop_valid;
        sel_free = free_en && !tagw_load && !push_valid && !pop_valid && !wr_en;
        push_ok  = sel_push && (tag_push == TAG_EMPTY);
        pop_ok   = sel_pop && (tag_top != TAG_EMPTY);
    end

    // Steer data writes and tag updates from the winning request.
    always_comb begin
        cls_in = push_ok ? push_data : wr_data;
        d_we   = push_ok || sel_wr;
        d_addr = push_ok ? push_phys : wr_phys;
        t_set  = push_ok || pop_ok || sel_wr || sel_free;
        if (push_ok) begin
            t_idx = push_phys;
        end else if (pop_ok) begin
            t_idx = top_q;
        end else if (sel_wr) begin
            t_idx = wr_phys;
        end else begin
            t_idx = free_phys;
        end
        t_val = (push_ok || sel_wr) ? cls_tag : TAG_EMPTY;
    end

    fpstk_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
        .value (cls_in),
        .tag   (cls_tag)
    );

    fpstk_datafile #(.DEPTH(NREG), .W(W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (d_we),
        .waddr (d_addr),
        .wdata (cls_in),
        .raddr (rd_phys),
        .rdata (rd_data)
    );

    fpstk_tagfile #(.DEPTH(NREG)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (tagw_load),
        .load_word (tagw_in),
        .set_en    (t_set),
        .set_idx   (t_idx),
        .set_tag   (t_val),
        .tag_word  (tagw_out)
    );

    // Move the top pointer on accepted push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (push_ok) begin
            top_q <= push_phys;
        end else if (pop_ok) begin
            top_q <= top_q + AW'(1);
        end
    end

    // Register one-cycle overflow and underflow pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= sel_push && !push_ok;
            unf_flag <= (sel_pop && !pop_ok) || (rd_en && tag_rd == TAG_EMPTY);
        end
    end

    assign top_ptr = top_q;
endmodule

// File: rtl/fpstk_chk.sv
// Protocol checker for fp_regstack, attached by bind; observes ports only.
module fpstk_chk #(
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG),
    localparam int TW  = 2 * NREG
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          pop_valid,
    input logic          free_en,
    input logic          wr_en,
    input logic [AW-1:0] free_idx,
    input logic          tagw_load,
    input logic [TW-1:0] tagw_in,
    input logic [TW-1:0] tagw_out,
    input logic [AW-1:0] top_ptr,
    input logic          ovf_flag,
    input logic          unf_flag
);
    function automatic logic [1:0] tg(input logic [TW-1:0] w, input logic [AW-1:0] i);
        return w[2*i +: 2];
    endfunction

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (tagw_out == '1 && top_ptr == '0 && !ovf_flag && !unf_flag));

    p_push_moves_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !tagw_load && tg(tagw_out, top_ptr - AW'(1)) == 2'b11)
        |=> (top_ptr == AW'($past(top_ptr) - AW'(1)) && !ovf_flag));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !tagw_load && tg(tagw_out, top_ptr - AW'(1)) != 2'b11)
        |=> (ovf_flag && $stable(top_ptr) && $stable(tagw_out)));

    p_pop_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !push_valid && !tagw_load && tg(tagw_out, top_ptr) != 2'b11)
        |=> (top_ptr == AW'($past(top_ptr) + AW'(1)) && tg(tagw_out, $past(top_ptr)) == 2'b11));

    p_pop_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !push_valid && !tagw_load && tg(tagw_out, top_ptr) == 2'b11)
        |=> (unf_flag && $stable(top_ptr)));

    p_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !wr_en && !pop_valid && !push_valid && !tagw_load)
        |=> ($stable(top_ptr) && tg(tagw_out, $past(top_ptr) + $past(free_idx)) == 2'b11));

    p_tag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tagw_load |=> (tagw_out == $past(tagw_in) && $stable(top_ptr) && !ovf_flag));

    p_flag_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> !ovf_flag || $past(push_valid));
endmodule

bind fp_regstack fpstk_chk #(.NREG(NREG)) u_fpstk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .free_en    (free_en),
    .wr_en      (wr_en),
    .free_idx   (free_idx),
    .tagw_load  (tagw_load),
    .tagw_in    (tagw_in),
    .tagw_out   (tagw_out),
    .top_ptr    (top_ptr),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/test_fp_regstack.sv
// Scoreboard bench: driver tasks predict post-edge state into a queue,
// a monitor compares each entry just after the clock edge.
module test_fp_regstack;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0, pop_valid = 1'b0, rd_en = 1'b0;
    logic        wr_en = 1'b0, free_en = 1'b0, tagw_load = 1'b0;
    logic [79:0] push_data = '0, wr_data = '0, rd_data;
    logic [2:0]  rd_idx = '0, wr_idx = '0, free_idx = '0, top_ptr;
    logic [15:0] tagw_in = '0, tagw_out;
    logic        ovf_flag, unf_flag;

    int checks = 0;
    int fails  = 0;

    always #HALF clk = ~clk;

    fp_regstack i_fp_regstack (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop_valid(pop_valid),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .free_en(free_en), .free_idx(free_idx),
        .tagw_load(tagw_load), .tagw_in(tagw_in), .tagw_out(tagw_out),
        .top_ptr(top_ptr), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct {
        string       req;
        logic [2:0]  top;
        logic [15:0] tw;
        logic        ovf;
        logic        unf;
        logic [79:0] st0;
    } exp_t;

    exp_t        sb[$];
    logic [2:0]  m_top = '0;
    logic [1:0]  m_tag [8];
    logic [79:0] m_reg [8];

    // Reference tag rule taken from the requirement text.
    function automatic logic [1:0] ref_tag(input logic [79:0] v);
        if (v[78:64] == 15'h0) return (v[63:0] == 64'h0) ? 2'b01 : 2'b10;
        if (v[78:64] == 15'h7FFF) return 2'b10;
        if (!v[63]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [15:0] m_word();
        logic [15:0] w;
        for (int n = 0; n < 8; n++) w[2*n +: 2] = m_tag[n];
        return w;
    endfunction

    // Drive one cycle of requests, predict the result, queue it.
    task automatic op(input string req,
                      input logic p, input logic [79:0] pd,
                      input logic o,
                      input logic w, input logic [2:0] wi, input logic [79:0] wd,
                      input logic f, input logic [2:0] fi,
                      input logic l, input logic [15:0] lw,
                      input logic r, input logic [2:0] ri);
        exp_t e;
        logic [2:0] tgt;
        logic eo, eu;
        @(negedge clk);
        push_valid = p; push_data = pd; pop_valid = o;
        wr_en = w; wr_idx = wi; wr_data = wd;
        free_en = f; free_idx = fi; tagw_load = l; tagw_in = lw;
        rd_en = r; rd_idx = ri;
        eo = 1'b0;
        eu = r && (m_tag[3'(m_top + ri)] == 2'b11);
        if (l) begin
            for (int n = 0; n < 8; n++) m_tag[n] = lw[2*n +: 2];
        end else if (p) begin
            tgt = m_top - 3'd1;
            if (m_tag[tgt] == 2'b11) begin
                m_reg[tgt] = pd; m_tag[tgt] = ref_tag(pd); m_top = tgt;
            end else eo = 1'b1;
        end else if (o) begin
            if (m_tag[m_top] != 2'b11) begin
                m_tag[m_top] = 2'b11; m_top = m_top + 3'd1;
            end else eu = 1'b1;
        end else if (w) begin
            tgt = m_top + wi;
            m_reg[tgt] = wd; m_tag[tgt] = ref_tag(wd);
        end else if (f) begin
            m_tag[3'(m_top + fi)] = 2'b11;
        end
        e.req = req; e.top = m_top; e.tw = m_word(); e.ovf = eo; e.unf = eu;
        e.st0 = m_reg[m_top];
        sb.push_back(e);
        @(posedge clk);
        #1;
        push_valid = 0; pop_valid = 0; wr_en = 0; free_en = 0;
        tagw_load = 0; rd_en = 0; rd_idx = '0;
    endtask

    task automatic push(input string req, input logic [79:0] v);
        op(req, 1, v, 0, 0, 0, '0, 0, 0, 0, '0, 0, 0);
    endtask
    task automatic pop(input string req);
        op(req, 0, '0, 1, 0, 0, '0, 0, 0, 0, '0, 0, 0);
    endtask

    // Read ST(i) combinationally and compare against the model.
    task automatic peek(input string req, input int i);
        logic [79:0] ex;
        @(negedge clk);
        rd_idx = 3'(i);
        #1;
        ex = m_reg[3'(m_top + 3'(i))];
        checks++;
        if (rd_data !== ex) begin
            fails++;
            $display("FAIL %s ST(%0d) got %h expected %h", req, i, rd_data, ex);
        end
        rd_idx = '0;
    endtask

    // Monitor: compare the oldest prediction just after each edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (top_ptr !== e.top || tagw_out !== e.tw || ovf_flag !== e.ovf ||
                unf_flag !== e.unf || rd_data !== e.st0) begin
                fails++;
                $display("FAIL %s top=%0d tw=%h ovf=%b unf=%b st0=%h expected top=%0d tw=%h ovf=%b unf=%b st0=%h",
                         e.req, top_ptr, tagw_out, ovf_flag, unf_flag, rd_data,
                         e.top, e.tw, e.ovf, e.unf, e.st0);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(2 * HALF * 50000);
        checks++; fails++;
        $display("FAIL watchdog expired got running expected finished");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < 8; n++) begin m_tag[n] = 2'b11; m_reg[n] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++; // R1 reset state
        if (top_ptr !== 3'd0 || tagw_out !== 16'hFFFF || ovf_flag || unf_flag) begin
            fails++;
            $display("FAIL R1 top=%0d tw=%h flags=%b%b expected 0 ffff 00",
                     top_ptr, tagw_out, ovf_flag, unf_flag);
        end
        // R2 and R6: fill all eight slots with one value of each class.
        push("R2 R6 valid",        80'h3FFF_8000000000000000);
        push("R6 zero",            80'h0);
        push("R6 denormal",        80'h0000_0000000000000001);
        push("R6 infinity",        80'h7FFF_8000000000000000);
        push("R6 unnormal",        80'h4000_0000000000000005);
        push("R6 nan",             80'hFFFF_C000000000000000);
        push("R2 negative valid",  80'hC000_8000000000000000);
        push("R6 pseudo denormal", 80'h0000_8000000000000000);
        push("R3 overflow",        80'h3FFF_8000000000000000);
        peek("R7 read ST3", 3);
        peek("R7 read ST7", 7);
        op("R7 write ST2", 0, '0, 0, 1, 3'd2, 80'h0, 0, 0, 0, '0, 0, 0);
        peek("R7 readback ST2", 2);
        op("R8 free ST1", 0, '0, 0, 0, 0, '0, 1, 3'd1, 0, '0, 0, 0);
        peek("R8 data kept ST1", 1);
        op("R5 read empty", 0, '0, 0, 0, 0, '0, 0, 0, 0, '0, 1, 3'd1);
        op("R5 read full no flag", 0, '0, 0, 0, 0, '0, 0, 0, 0, '0, 1, 3'd0);
        pop("R4 pop");
        pop("R5 pop empty");
        op("R10 push beats pop", 1, 80'h4001_C000000000000000, 1, 0, 0, '0, 0, 0, 0, '0, 0, 0);
        op("R10 write beats free", 0, '0, 0, 1, 3'd3, 80'h7FFF_0000000000000000, 1, 3'd3, 0, '0, 0, 0);
        op("R9 R10 load beats push", 1, 80'h3FFF_8000000000000000, 0, 0, 0, '0, 0, 0, 1, 16'h0F0F, 0, 0);
        push("R9 R3 loaded tag blocks push", 80'h3FFF_8000000000000000);
        op("R9 load all empty", 0, '0, 0, 0, 0, '0, 0, 0, 1, 16'hFFFF, 0, 0);
        push("R2 push after load", 80'h4005_A000000000000000);
        op("R7 write empty slot", 0, '0, 0, 1, 3'd5, 80'h3FFE_8000000000000001, 0, 0, 0, '0, 0, 0);
        pop("R4 pop wrap");
        pop("R5 R11 pop empty");
        pop("R11 flag repeats only on request");
        op("R11 idle clears flag", 0, '0, 0, 0, 0, '0, 0, 0, 0, '0, 0, 0);
        repeat (3) @(posedge clk);
        #3;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule